// File: doc/BRIEF.md
# SAR Conversion Timing Sequencer

This block runs one successive-approximation conversion. A start strobe, accepted only while the block is idle, captures the channel, the resolution, the reference-select bit and the sampling length. The conversion then passes through three timed phases: an optional precharge, an input sampling window, and an evaluation phase that decides one result bit per clock, most significant bit first. The analog DAC and comparator sit outside the block. The block drives the trial code to the DAC and samples the comparator answer at the end of each evaluation cycle.

Channel numbers also select the reference. Channels below a configurable boundary use the captured reference-select bit. Channels at or above that boundary, which includes the test channels 96 to 127, use a fixed selection. The four highest channels each drive one line of a one-hot self-test reference select while they are being converted. Test channels are otherwise sequenced exactly like normal ones.

Top module: `sar_conv_seq`

## Requirements
- R1: `start_i` is accepted only while `busy_o` is low. When it is accepted, `busy_o` rises one clock later. A start pulse while busy changes neither the phase lengths, nor `refsel_o`/`selftest_o`, nor the result.
- R2: `prechg_o` is high for exactly P consecutive cycles immediately after the start is accepted, where P is `prechg_cyc_i` at the start. P = 0 skips the precharge phase and goes straight to sampling.
- R3: `sample_o` is high for exactly max(S, 5) consecutive cycles directly after precharge, where S is `samp_cyc_i` at the start. Any value below 5 behaves as 5.
- R4: `sample_o` is low for the whole evaluation phase. `prechg_o` and `sample_o` are never high together.
- R5: Evaluation lasts 12 cycles when `res12_i` = 1 and 10 cycles when it is 0. `busy_o` stays high for P + max(S,5) + that count cycles.
- R6: In the first evaluation cycle `dac_code_o` has only the top result bit set (bit 11 in 12-bit mode, bit 9 in 10-bit mode). In each evaluation cycle, `cmp_i` = 1 at the closing edge keeps the trial bit and 0 clears it. The next lower bit is tried next. `dac_code_o` is zero outside evaluation.
- R7: In 10-bit mode the result is right-aligned in `result_o`, and bits 11:10 of both `result_o` and `dac_code_o` are zero.
- R8: `done_o` is high for exactly one cycle, the first cycle after `busy_o` falls. `result_o` takes the new value in that cycle and holds it until the next `done_o`.
- R9: While busy, `refsel_o` equals the `refsel_i` captured at start for channels below 96. For channels 96 and above it is the fixed value 0. It is 0 while idle.
- R10: While busy on channel 124+k (k = 0..3), `selftest_o` is one-hot with bit k set. In all other cases it is zero.
- R11: After reset, `busy_o`, `done_o`, `prechg_o`, `sample_o`, `refsel_o`, `selftest_o`, `dac_code_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request strobe |
| chan_i | input | 7 | Channel number |
| prechg_cyc_i | input | 8 | Precharge length in cycles (0 skips) |
| samp_cyc_i | input | 8 | Sampling length in cycles (minimum 5) |
| res12_i | input | 1 | 1 = 12-bit, 0 = 10-bit conversion |
| refsel_i | input | 1 | Per-channel reference-select bit |
| cmp_i | input | 1 | Comparator result: input at or above trial code |
| prechg_o | output | 1 | Precharge switch control |
| sample_o | output | 1 | Sample switch control |
| dac_code_o | output | 12 | Trial code to the DAC |
| refsel_o | output | 1 | Reference select for the conversion |
| selftest_o | output | 4 | One-hot self-test reference select |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result-update pulse |
| result_o | output | 12 | Last conversion result |

## Verification
The conversion is driven by a behavioural comparator that answers against a target code. The targets used are all zeros, all ones, a lone MSB, an MSB-clear all-ones value and alternating patterns. These tell apart a bit kept by mistake from one cleared by mistake, and they catch an off-by-one in the bit order. Precharge counts of zero and non-zero, and sampling counts below, at and above the minimum, separate the skip and clamp paths from plain counting. Normal, fixed-reference and self-test channels in both resolutions separate the reference decode from the timing. A start pulse issued mid-conversion shows whether a busy request leaks into the running conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_SAMP = 2'd2,
        PH_EVAL = 2'd3
    } phase_e;
endpackage

// File: rtl/sar_samp_clamp.sv
module sar_samp_clamp #(
    parameter int CNT_W    = 8,
    parameter int MIN_SAMP = 5
) (
    input  logic [CNT_W-1:0] req_i,
    output logic [CNT_W-1:0] eff_o
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_SAMP);

    always_comb begin
        eff_o = (req_i < MIN_V) ? MIN_V : req_i;
    end
endmodule

// File: rtl/sar_trial_step.sv
module sar_trial_step #(
    parameter int RES_W = 12,
    parameter int IDX_W = 4
) (
    input  logic [RES_W-1:0] code_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] trial_o,
    output logic [RES_W-1:0] next_o
);
    logic [RES_W-1:0] bit_mask;

    always_comb begin
        bit_mask = {{(RES_W-1){1'b0}}, 1'b1} << idx_i;
        trial_o  = code_i | bit_mask;
        next_o   = cmp_i ? trial_o : (code_i & ~bit_mask);
    end
endmodule

// File: rtl/sar_ref_decode.sv
module sar_ref_decode #(
    parameter int   CH_W            = 7,
    parameter int   FIXED_REF_FIRST = 96,
    parameter logic FIXED_REF_VAL   = 1'b0,
    parameter int   SELFTEST_FIRST  = 124,
    parameter int   NUM_SELFTEST    = 4
) (
    input  logic                    active_i,
    input  logic [CH_W-1:0]         chan_i,
    input  logic                    refsel_i,
    output logic                    refsel_o,
    output logic [NUM_SELFTEST-1:0] selftest_o
);
    localparam logic [CH_W-1:0] FIX_CH = CH_W'(FIXED_REF_FIRST);

    always_comb begin
        refsel_o = active_i && ((chan_i >= FIX_CH) ? FIXED_REF_VAL : refsel_i);
    end

    for (genvar k = 0; k < NUM_SELFTEST; k++) begin : g_st
        assign selftest_o[k] = active_i && (chan_i == CH_W'(SELFTEST_FIRST + k));
    end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int   CH_W            = 7,
    parameter int   CNT_W           = 8,
    parameter int   RES_W           = 12,
    parameter int   LOW_RES_W       = 10,
    parameter int   MIN_SAMP        = 5,
    parameter int   FIXED_REF_FIRST = 96,
    parameter logic FIXED_REF_VAL   = 1'b0,
    parameter int   SELFTEST_FIRST  = 124,
    parameter int   NUM_SELFTEST    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [CH_W-1:0]         chan_i,
    input  logic [CNT_W-1:0]        prechg_cyc_i,
    input  logic [CNT_W-1:0]        samp_cyc_i,
    input  logic                    res12_i,
    input  logic                    refsel_i,
    input  logic                    cmp_i,
    output logic                    prechg_o,
    output logic                    sample_o,
    output logic [RES_W-1:0]        dac_code_o,
    output logic                    refsel_o,
    output logic [NUM_SELFTEST-1:0] selftest_o,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [RES_W-1:0]        result_o
);
    localparam int IDX_W = $clog2(RES_W);
    localparam logic [IDX_W-1:0] TOP_HI = IDX_W'(RES_W - 1);
    localparam logic [IDX_W-1:0] TOP_LO = IDX_W'(LOW_RES_W - 1);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [RES_W-1:0] code;
        logic             hires;
        logic [CH_W-1:0]  chan;
        logic             refsel;
        logic [CNT_W-1:0] samp;
        logic [RES_W-1:0] result;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;

    logic [CNT_W-1:0] samp_eff;
    logic [RES_W-1:0] trial_code, next_code;

    sar_samp_clamp #(.CNT_W(CNT_W), .MIN_SAMP(MIN_SAMP)) u_clamp (
        .req_i (samp_cyc_i),
        .eff_o (samp_eff)
    );

    sar_trial_step #(.RES_W(RES_W), .IDX_W(IDX_W)) u_step (
        .code_i  (s_q.code),
        .idx_i   (s_q.idx),
        .cmp_i   (cmp_i),
        .trial_o (trial_code),
        .next_o  (next_code)
    );

    sar_ref_decode #(
        .CH_W            (CH_W),
        .FIXED_REF_FIRST (FIXED_REF_FIRST),
        .FIXED_REF_VAL   (FIXED_REF_VAL),
        .SELFTEST_FIRST  (SELFTEST_FIRST),
        .NUM_SELFTEST    (NUM_SELFTEST)
    ) u_ref (
        .active_i   (busy_o),
        .chan_i     (s_q.chan),
        .refsel_i   (s_q.refsel),
        .refsel_o   (refsel_o),
        .selftest_o (selftest_o)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.chan   = chan_i;
                    s_d.refsel = refsel_i;
                    s_d.hires  = res12_i;
                    s_d.samp   = samp_eff;
                    s_d.code   = '0;
                    if (prechg_cyc_i != '0) begin
                        s_d.phase = PH_PRE;
                        s_d.cnt   = prechg_cyc_i - ONE;
                    end else begin
                        s_d.phase = PH_SAMP;
                        s_d.cnt   = samp_eff - ONE;
                    end
                end
            end
            PH_PRE: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_SAMP;
                    s_d.cnt   = s_q.samp - ONE;
                end else begin
                    s_d.cnt = s_q.cnt - ONE;
                end
            end
            PH_SAMP: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_EVAL;
                    s_d.idx   = s_q.hires ? TOP_HI : TOP_LO;
                end else begin
                    s_d.cnt = s_q.cnt - ONE;
                end
            end
            PH_EVAL: begin
                s_d.code = next_code;
                if (s_q.idx == '0) begin
                    s_d.phase  = PH_IDLE;
                    s_d.result = next_code;
                    s_d.done   = 1'b1;
                end else begin
                    s_d.idx = s_q.idx - 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o     = (s_q.phase != PH_IDLE);
    assign prechg_o   = (s_q.phase == PH_PRE);
    assign sample_o   = (s_q.phase == PH_SAMP);
    assign dac_code_o = (s_q.phase == PH_EVAL) ? trial_code : '0;
    assign done_o     = s_q.done;
    assign result_o   = s_q.result;

    // R4: switches never closed together
    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(prechg_o && sample_o));

    // R8: done follows the last busy cycle and lasts one cycle
    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    // R1, R9: reference controls hold for a whole conversion
    p_ref_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(refsel_o) && $stable(selftest_o)));

    // R10: self-test select is one-hot or idle
    p_selftest_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(selftest_o) && (busy_o || selftest_o == '0));

    // R7: low-resolution trials never touch the upper bits
    p_lowres_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !s_q.hires) |-> (dac_code_o[RES_W-1:LOW_RES_W] == '0));

    // R6: DAC code only driven during evaluation
    p_dac_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (prechg_o || sample_o || !busy_o) |-> (dac_code_o == '0));
endmodule

// File: tb/sim_sar_conv_seq.sv
module sim_sar_conv_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [6:0]  chan_i = '0;
    logic [7:0]  prechg_cyc_i = '0;
    logic [7:0]  samp_cyc_i = '0;
    logic        res12_i = 1'b0;
    logic        refsel_i = 1'b0;
    logic        cmp_i;
    logic        prechg_o, sample_o, refsel_o, busy_o, done_o;
    logic [11:0] dac_code_o, result_o;
    logic [3:0]  selftest_o;
    logic [11:0] vin_q = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // behavioural comparator: input at or above trial code
    assign cmp_i = (dac_code_o <= vin_q);

    sar_conv_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .prechg_cyc_i(prechg_cyc_i), .samp_cyc_i(samp_cyc_i),
        .res12_i(res12_i), .refsel_i(refsel_i), .cmp_i(cmp_i),
        .prechg_o(prechg_o), .sample_o(sample_o), .dac_code_o(dac_code_o),
        .refsel_o(refsel_o), .selftest_o(selftest_o), .busy_o(busy_o),
        .done_o(done_o), .result_o(result_o)
    );

    localparam int NV = 8;
    localparam logic [6:0]  V_CH [NV] = '{7'd3, 7'd10, 7'd20, 7'd40, 7'd100, 7'd124, 7'd127, 7'd126};
    localparam logic [7:0]  V_P  [NV] = '{8'd2, 8'd0, 8'd1, 8'd4, 8'd2, 8'd1, 8'd3, 8'd0};
    localparam logic [7:0]  V_S  [NV] = '{8'd6, 8'd5, 8'd3, 8'd0, 8'd8, 8'd5, 8'd7, 8'd2};
    localparam logic        V_HI [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam logic        V_RS [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic [11:0] V_IN [NV] = '{12'hA5C, 12'h000, 12'hFFF, 12'h2AB, 12'h800, 12'h3FF, 12'h7FF, 12'h155};

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_conv(input logic [6:0] ch, input logic [7:0] p, input logic [7:0] s,
                            input logic hi, input logic rs, input logic [11:0] vin, input bit glitch);
        int pre_n = 0, smp_n = 0, ev_n = 0, n = 0;
        int exp_s, exp_ev;
        logic [11:0] first_dac = '0;
        logic [11:0] exp_res;
        logic        up_bad = 1'b0, order_bad = 1'b0, ref_bad = 1'b0, seen_eval = 1'b0;
        logic        exp_ref;
        logic [3:0]  exp_st;
        exp_s   = (s < 8'd5) ? 5 : int'(s);
        exp_ev  = hi ? 12 : 10;
        exp_res = hi ? vin : (vin & 12'h3FF);
        exp_ref = (ch < 7'd96) ? rs : 1'b0;
        exp_st  = (ch >= 7'd124) ? (4'b0001 << (ch - 7'd124)) : 4'b0000;
        @(negedge clk);
        vin_q = exp_res; chan_i = ch; prechg_cyc_i = p; samp_cyc_i = s;
        res12_i = hi; refsel_i = rs; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R1 busy after start", int'(busy_o), 1);
        while (busy_o && n < 2000) begin
            if (prechg_o) begin
                pre_n++;
                if (smp_n != 0 || seen_eval) order_bad = 1'b1;
            end else if (sample_o) begin
                smp_n++;
                if (seen_eval) order_bad = 1'b1;
            end else begin
                if (!seen_eval) first_dac = dac_code_o;
                seen_eval = 1'b1;
                ev_n++;
                if (!hi && dac_code_o[11:10] != 2'b00) up_bad = 1'b1;
            end
            if (refsel_o != exp_ref || selftest_o != exp_st) ref_bad = 1'b1;
            if (glitch && n == 2) begin
                start_i = 1'b1; chan_i = 7'd124; refsel_i = ~rs; prechg_cyc_i = 8'd9;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        chk(n < 2000, "R5 watchdog", n, 0);
        chk(pre_n == int'(p), "R2 precharge cycles", pre_n, int'(p));
        chk(smp_n == exp_s, "R3 sample cycles", smp_n, exp_s);
        chk(ev_n == exp_ev, "R5 eval cycles", ev_n, exp_ev);
        chk(n == int'(p) + exp_s + exp_ev, "R5 busy length", n, int'(p) + exp_s + exp_ev);
        chk(!order_bad, "R4 phase order", int'(order_bad), 0);
        chk(first_dac == (hi ? 12'h800 : 12'h200), "R6 first trial code", first_dac, hi ? 12'h800 : 12'h200);
        chk(!up_bad, "R7 upper trial bits", int'(up_bad), 0);
        chk(!ref_bad, "R9 R10 reference selects", int'(ref_bad), 0);
        chk(done_o == 1'b1, "R8 done pulse", int'(done_o), 1);
        chk(result_o == exp_res, "R6 result", result_o, exp_res);
        @(negedge clk);
        chk(done_o == 1'b0, "R8 done single cycle", int'(done_o), 0);
        chk(result_o == exp_res, "R8 result held", result_o, exp_res);
        chk(refsel_o == 1'b0 && selftest_o == 4'b0, "R9 idle refs", {refsel_o, selftest_o}, 0);
    endtask

    initial begin
        #15;
        @(negedge clk);
        // R11 reset state
        chk(busy_o == 0 && done_o == 0 && prechg_o == 0 && sample_o == 0, "R11 reset ctrl",
            {busy_o, done_o, prechg_o, sample_o}, 0);
        chk(dac_code_o == 0 && result_o == 0 && refsel_o == 0 && selftest_o == 0, "R11 reset data",
            {dac_code_o, result_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R11 idle after reset", int'(busy_o), 0);
        for (int i = 0; i < NV; i++) begin
            run_conv(V_CH[i], V_P[i], V_S[i], V_HI[i], V_RS[i], V_IN[i], 1'b0);
        end
        // R1: start while busy is ignored
        run_conv(7'd5, 8'd1, 8'd5, 1'b1, 1'b1, 12'h123, 1'b1);
        // R7: 10-bit full scale stays right-aligned
        run_conv(7'd50, 8'd0, 8'd5, 1'b0, 1'b0, 12'h3FF, 1'b0);
        chk(result_o[11:10] == 2'b00, "R7 result upper bits", result_o[11:10], 0);
        // R6: alternating pattern, minimum sampling from zero request
        run_conv(7'd125, 8'd0, 8'd0, 1'b1, 1'b0, 12'h555, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #3000000;
        checks++;
        errors++;
        $display("FAIL R5 watchdog expired: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule